// File: doc/BRIEF.md
# Boot Source and Software Reset Controller

This block decides where the CPU begins fetching after every reset, and it produces the reset that software requests when it wants to reboot. It sees three static configuration option bits, an asynchronous power-on reset, a synchronous external reset, and byte writes to a control register. From these it drives the CPU reset line and a boot-region select. The select puts the start vector either at application address 0x0000 or at the base of the loader region.

The primary boot option and the loader-region enable together send the CPU to the loader after power-on. A secondary option also sends it to the loader after an external reset. A loader program finishes by writing the pattern 101 into the top three bits of the control register. That write holds the CPU in reset for a fixed number of cycles and then releases it into application memory, whatever the option bits are set to. The cause of the latest reset is kept in a register, so the select does not move while a reset pulse is in progress.

Top module: `boot_rst_ctl`

## Requirements
- R1: While `por_i` is high, and after it is released, `boot_ldr_o` is 1 if and only if `opt_hw_boot_i` and `opt_ldr_en_i` are both 1.
- R2: After an external reset, `boot_ldr_o` is 1 when `opt_hw_boot_i`, `opt_hw_boot2_i` and `opt_ldr_en_i` are all 1.
- R3: After an external reset, `boot_ldr_o` is 0 if `opt_hw_boot2_i` is 0, or if either `opt_hw_boot_i` or `opt_ldr_en_i` is 0.
- R4: If `opt_hw_boot_i` or `opt_ldr_en_i` is 0, every reset ends with `boot_ldr_o` = 0 and `boot_vec_o` = 0x0000.
- R5: A write (`ctl_wr_i` = 1) with `ctl_wdata_i[7:5]` = 3'b101, made while `cpu_rst_o` is low, raises `cpu_rst_o` from the next cycle for exactly `PULSE_CYC` cycles. The value of bits 4:0 does not matter.
- R6: During and after a software reset, `boot_ldr_o` is 0 and `boot_vec_o` is 0x0000, for any setting of the option bits.
- R7: A write whose bits 7:5 differ from 3'b101 leaves `cpu_rst_o` low and `boot_ldr_o` unchanged.
- R8: A write made while `cpu_rst_o` is high has no effect: the pulse in progress neither lengthens nor restarts.
- R9: `cpu_rst_o` is high in any cycle in which `por_i` or `ext_rst_i` is high. An external reset during a software pulse ends that pulse and becomes the recorded reset cause.
- R10: `boot_vec_o` is `LDR_BASE` when `boot_ldr_o` is 1, and 0 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| ext_rst_i | input | 1 | External reset, active high, sampled on the clock |
| opt_hw_boot_i | input | 1 | Primary hardware boot-select option |
| opt_hw_boot2_i | input | 1 | Secondary boot-select option (loader boot also after external reset) |
| opt_ldr_en_i | input | 1 | Loader region enable option |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| cpu_rst_o | output | 1 | CPU reset, active high |
| boot_ldr_o | output | 1 | 1 = start in loader region, 0 = start in application memory |
| boot_vec_o | output | ADDR_W | Start vector address |

## Verification
If the recorded reset cause is wrong, `boot_ldr_o` and `boot_vec_o` show it in the first cycle after the reset event, because both outputs decode that register directly. A counter that is off shows up on `cpu_rst_o` in the cycle where the pulse should have ended, or on the first write that ought to be ignored. The bench follows the cause and the remaining pulse length in its own model and compares all three outputs in every cycle, so each such error appears at the cycle it first occurs.

// File: rtl/boot_rst_ctl.sv
module boot_rst_ctl #(
  parameter int ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] LDR_BASE = 16'hF000,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              ext_rst_i,
  input  logic              opt_hw_boot_i,
  input  logic              opt_hw_boot2_i,
  input  logic              opt_ldr_en_i,
  input  logic              ctl_wr_i,
  input  logic [7:0]        ctl_wdata_i,
  output logic              cpu_rst_o,
  output logic              boot_ldr_o,
  output logic [ADDR_W-1:0] boot_vec_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC);
  localparam logic [2:0] SW_KEY = 3'b101;

  typedef enum logic [1:0] {CAUSE_POR, CAUSE_EXT, CAUSE_SW} cause_t;

  cause_t           cause_q;
  logic [CNT_W-1:0] sw_cnt_q;
  logic             sw_busy, sw_req;

  assign sw_busy = (sw_cnt_q != '0);
  assign sw_req  = ctl_wr_i && (ctl_wdata_i[7:5] == SW_KEY) && !sw_busy;

  always_ff @(posedge clk or posedge por_i) begin
    if (por_i) begin
      cause_q  <= CAUSE_POR;
      sw_cnt_q <= '0;
    end else if (ext_rst_i) begin
      cause_q  <= CAUSE_EXT;
      sw_cnt_q <= '0;
    end else if (sw_busy) begin
      sw_cnt_q <= sw_cnt_q - 1'b1;
    end else if (sw_req) begin
      cause_q  <= CAUSE_SW;
      sw_cnt_q <= PULSE_LD;
    end
  end

  assign cpu_rst_o  = por_i || ext_rst_i || sw_busy;
  assign boot_ldr_o = opt_hw_boot_i && opt_ldr_en_i &&
                      ((cause_q == CAUSE_POR) || (cause_q == CAUSE_EXT && opt_hw_boot2_i));
  assign boot_vec_o = boot_ldr_o ? LDR_BASE : '0;
endmodule

module boot_rst_ctl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             por_i,
  input logic             ext_rst_i,
  input logic             opt_hw_boot_i,
  input logic             opt_hw_boot2_i,
  input logic             opt_ldr_en_i,
  input logic             ctl_wr_i,
  input logic [7:0]       ctl_wdata_i,
  input logic             cpu_rst_o,
  input logic             boot_ldr_o,
  input logic [CNT_W-1:0] sw_cnt
);
  // R6
  sw_boot_app_chk: assert property (@(posedge clk) disable iff (por_i)
    (sw_cnt != '0) |-> !boot_ldr_o);
  // R5
  sw_key_starts_chk: assert property (@(posedge clk) disable iff (por_i)
    (ctl_wr_i && ctl_wdata_i[7:5] == 3'b101 && !cpu_rst_o) |=> (cpu_rst_o && !boot_ldr_o));
  // R7
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (por_i)
    (ctl_wr_i && ctl_wdata_i[7:5] != 3'b101 && !cpu_rst_o) |=> (!cpu_rst_o || ext_rst_i));
  // R3
  ext_no_opt2_chk: assert property (@(posedge clk) disable iff (por_i)
    (ext_rst_i && !opt_hw_boot2_i) |=> !boot_ldr_o);
  // R4
  ldr_needs_opts_chk: assert property (@(posedge clk) disable iff (por_i)
    boot_ldr_o |-> (opt_hw_boot_i && opt_ldr_en_i));
  // R9
  ext_holds_rst_chk: assert property (@(posedge clk) disable iff (por_i)
    ext_rst_i |-> cpu_rst_o);
endmodule

bind boot_rst_ctl boot_rst_ctl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .por_i(por_i), .ext_rst_i(ext_rst_i),
  .opt_hw_boot_i(opt_hw_boot_i), .opt_hw_boot2_i(opt_hw_boot2_i),
  .opt_ldr_en_i(opt_ldr_en_i), .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
  .cpu_rst_o(cpu_rst_o), .boot_ldr_o(boot_ldr_o), .sw_cnt(sw_cnt_q)
);

// File: tb/boot_rst_ctl_tb.sv
`timescale 1ns/1ps
module boot_rst_ctl_tb_top;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] LDR_BASE = 16'hF000;
  localparam int PULSE_CYC = 4;

  logic clk = 0, por = 1, ext = 0, hw = 1, hw2 = 1, ldr = 1, wr = 0;
  logic [7:0] wd = 0;
  logic cpu_rst, boot_ldr;
  logic [ADDR_W-1:0] boot_vec;
  int n_run = 0, n_fail = 0;

  // model state: 0 = power-on, 1 = external, 2 = software
  int m_cause = 0, m_cnt = 0;

  always #4 clk = ~clk;

  boot_rst_ctl #(.ADDR_W(ADDR_W), .LDR_BASE(LDR_BASE), .PULSE_CYC(PULSE_CYC)) dut_i (
    .clk(clk), .por_i(por), .ext_rst_i(ext), .opt_hw_boot_i(hw), .opt_hw_boot2_i(hw2),
    .opt_ldr_en_i(ldr), .ctl_wr_i(wr), .ctl_wdata_i(wd),
    .cpu_rst_o(cpu_rst), .boot_ldr_o(boot_ldr), .boot_vec_o(boot_vec));

  function automatic logic exp_ldr();
    return hw && ldr && (m_cause == 0 || (m_cause == 1 && hw2));
  endfunction

  function automatic string cause_tag();
    if (!(hw && ldr)) return "R4";
    if (m_cause == 0) return "R1";
    if (m_cause == 1) return hw2 ? "R2" : "R3";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic p, logic e, logic w, logic [7:0] d);
    logic el;
    @(negedge clk);
    por = p; ext = e; wr = w; wd = d;
    if (p) begin m_cause = 0; m_cnt = 0; end
    #1;
    el = exp_ldr();
    // R9 / R5 / R8
    chk((m_cnt != 0) ? "R5" : "R9", 32'(cpu_rst), 32'(p || e || m_cnt != 0));
    chk(cause_tag(), 32'(boot_ldr), 32'(el));
    // R10
    chk("R10", 32'(boot_vec), el ? 32'(LDR_BASE) : 32'h0);
    @(posedge clk); #1;
    if (p) begin m_cause = 0; m_cnt = 0; end
    else if (e) begin m_cause = 1; m_cnt = 0; end
    else if (m_cnt != 0) m_cnt--;
    else if (w && d[7:5] == 3'b101) begin m_cause = 2; m_cnt = PULSE_CYC; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00);
  endtask

  task automatic por_with(logic a, logic b, logic c);
    @(negedge clk); hw = a; hw2 = b; ldr = c;
    step(1, 0, 0, 0); step(1, 0, 0, 0);
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    // R1 reset state with loader options
    por_with(1, 1, 1); idle(3);
    // R2 external reset with all options
    step(0, 1, 0, 0); idle(2);
    // R5 R6 key 101 with arbitrary low bits, pulse length
    step(0, 0, 1, 8'hBF); idle(PULSE_CYC + 2);
    // R7 wrong patterns
    step(0, 0, 1, 8'hE0); step(0, 0, 1, 8'h80); step(0, 0, 1, 8'h1F); idle(2);
    // R3 external reset without secondary option
    por_with(1, 0, 1); step(0, 1, 0, 0); idle(2);
    // R8 writes during a pulse are ignored
    step(0, 0, 1, 8'hA0); step(0, 0, 1, 8'hA0); step(0, 0, 1, 8'hA5); idle(PULSE_CYC + 1);
    // R9 external reset aborts a pulse
    por_with(1, 1, 1); idle(1);
    step(0, 0, 1, 8'hA0); idle(1); step(0, 1, 0, 0); idle(3);
    // R4 loader disabled
    por_with(1, 1, 0); idle(1); step(0, 1, 0, 0); idle(1);
    por_with(0, 1, 1); idle(1);
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) begin
        por_with(1'($urandom), 1'($urandom), 1'($urandom));
      end else if (r < 6) step(0, 1, 0, 0);
      else if (r < 14) step(0, 0, 1, {3'b101, 5'($urandom)});
      else if (r < 22) step(0, 0, 1, 8'($urandom));
      else step(0, 0, 0, 8'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule